// File: doc/BRIEF.md
# Host Parallel Port Mailbox

This block sits between an external host processor and an embedded controller. They exchange single bytes over an 8-bit parallel bus with two active-low strobes. The host pulses the write strobe low to leave a byte in the input buffer. It pulses the read strobe low to collect the byte the controller placed in the output buffer. Each direction has a full flag, reported to the host on two flag outputs and to the controller in a status register. Each full condition can also raise an interrupt toward the controller.

The controller side uses a small synchronous register bus with four addresses: data, status, control and latch. A mode bit selects between two modes. In strobed mode the handshake above runs. In non-strobed mode the bus behaves as a plain bidirectional port: the outputs continuously show a latch, and the pins can be read back directly. Both strobes are asynchronous to the controller clock. They are synchronized, and only their falling edges act. On each host write, an auxiliary flag input is latched with the data byte.

Top module: `host_mailbox`

## Requirements
- R1: After reset the status register (address 1) reads 0. The control register (address 2) reads 0x01, which is strobed mode. host_data_oe_o is 0 while host_rd_ni is high, and both interrupts are 0.
- R2: In strobed mode, a falling edge on host_wr_ni is acted on within three clock edges. The byte on host_data_i is stored in the input buffer, status bit 0 (input full) is set, and host_flag_i is latched into status bit 4.
- R3: A register read of address 0 returns the input buffer, and the same cycle clears status bit 0.
- R4: A host write while status bit 0 is already set overwrites the input buffer and sets status bit 3 (overrun). The bit stays set until a register write to address 1 with bit 3 = 1.
- R5: A register write to address 0 loads the output buffer, sets status bit 1 (output full) and clears status bit 2 (host has read).
- R6: In strobed mode, host_data_oe_o equals the inverse of host_rd_ni, and host_data_o carries the output buffer. A falling edge on host_rd_ni clears status bit 1 and sets status bit 2.
- R7: With control bit 0 = 0 (non-strobed mode), host_data_oe_o is 1 and host_data_o equals the latch written at address 3. Strobes change no status bit, and a read of address 3 returns host_data_i.
- R8: irq_in_o = ctrl bit 3 (global enable) AND ctrl bit 1 AND status bit 0. irq_out_o = ctrl bit 3 AND ctrl bit 2 AND status bit 2.
- R9: host_flag_o[0] shows status bit 0 and host_flag_o[1] shows status bit 1.
- R10: Control register bits 3:0 are written at address 2 and read back there, with the upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_data_i | input | 8 | Host bus pin input |
| host_data_o | output | 8 | Host bus pin output value |
| host_data_oe_o | output | 1 | Host bus output enable |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_flag_i | input | 1 | Auxiliary flag, latched on host write |
| host_flag_o | output | 2 | Flags to host: [0] input full, [1] output full |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write enable |
| reg_rd_i | input | 1 | Register read enable (side effect at address 0) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_in_o | output | 1 | Input-full interrupt request |
| irq_out_o | output | 1 | Output-read interrupt request |

## Verification
The hardest condition to reach is an overrun: the host must write a second time before the controller drains the first byte. The clear must then be seen to happen only on the dedicated status write, and not on a data read. The random stimulus picks host writes, host reads, data reads, data writes and interrupt-enable changes with uneven weights, so back-to-back host writes occur often. Directed sequences pin down the non-strobed mode, where strobes must leave every flag untouched.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_STAT  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_LATCH = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_IBF  = 0;
  localparam int unsigned ST_OBF  = 1;
  localparam int unsigned ST_PEND = 2;
  localparam int unsigned ST_OVR  = 3;
  localparam int unsigned ST_FLAG = 4;
  localparam int unsigned ST_W    = 5;

  typedef struct packed {
    logic gie;
    logic ie_out;
    logic ie_in;
    logic strobed;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/hmb_strobe_sync.sv
module hmb_strobe_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_ni,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], strobe_ni[g]};
        prev_q <= pipe_q[STAGES-1];
      end
    end
    assign fall_o[g] = prev_q & ~pipe_q[STAGES-1];
  end
endmodule

// File: rtl/hmb_in_buf.sv
module hmb_in_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] host_data_i,
  input  logic          host_flag_i,
  input  logic          drain_i,
  input  logic          ovr_clr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      // host write wins over a same-cycle drain
      if (capture_i) begin
        data_o <= host_data_i;
        flag_o <= host_flag_i;
        full_o <= 1'b1;
      end else if (drain_i) begin
        full_o <= 1'b0;
      end
      ovr_o <= (ovr_o & ~ovr_clr_i) | (capture_i & full_o & ~drain_i);
    end
  end
endmodule

// File: rtl/hmb_out_buf.sv
module hmb_out_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          latch_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          taken_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] latch_o,
  output logic          full_o,
  output logic          pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      latch_o <= '0;
      full_o  <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (latch_wr_i) latch_o <= wdata_i;
      // controller load wins over a same-cycle host read
      if (load_i) begin
        data_o <= wdata_i;
        full_o <= 1'b1;
        pend_o <= 1'b0;
      end else if (taken_i) begin
        full_o <= 1'b0;
        pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import hmb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  input  logic              host_wr_ni,
  input  logic              host_rd_ni,
  input  logic              host_flag_i,
  output logic [1:0]        host_flag_o,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_in_o,
  output logic              irq_out_o
);
  ctrl_t             ctrl_q;
  logic [1:0]        fall;
  logic              wr_evt, rd_evt;
  logic              data_rd, data_wr, stat_wr, ctrl_wr, latch_wr, ovr_clr;
  logic [DATA_W-1:0] ibuf, obuf, latch;
  logic              ibf, obf, pend, ovr, flag_q;
  logic [ST_W-1:0]   status;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(reg_addr_i);

  hmb_strobe_sync #(.N(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni({host_rd_ni, host_wr_ni}),
    .fall_o   (fall)
  );

  assign wr_evt   = fall[0] & ctrl_q.strobed;
  assign rd_evt   = fall[1] & ctrl_q.strobed;
  assign data_rd  = reg_rd_i & (addr == REG_DATA);
  assign data_wr  = reg_wr_i & (addr == REG_DATA);
  assign stat_wr  = reg_wr_i & (addr == REG_STAT);
  assign ctrl_wr  = reg_wr_i & (addr == REG_CTRL);
  assign latch_wr = reg_wr_i & (addr == REG_LATCH);
  assign ovr_clr  = stat_wr & reg_wdata_i[ST_OVR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '{strobed: 1'b1, default: 1'b0};
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  hmb_in_buf #(.DW(DATA_W)) in_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (wr_evt),
    .host_data_i(host_data_i),
    .host_flag_i(host_flag_i),
    .drain_i    (data_rd),
    .ovr_clr_i  (ovr_clr),
    .data_o     (ibuf),
    .full_o     (ibf),
    .ovr_o      (ovr),
    .flag_o     (flag_q)
  );

  hmb_out_buf #(.DW(DATA_W)) out_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (data_wr),
    .latch_wr_i(latch_wr),
    .wdata_i   (reg_wdata_i),
    .taken_i   (rd_evt),
    .data_o    (obuf),
    .latch_o   (latch),
    .full_o    (obf),
    .pend_o    (pend)
  );

  always_comb begin
    status          = '0;
    status[ST_IBF]  = ibf;
    status[ST_OBF]  = obf;
    status[ST_PEND] = pend;
    status[ST_OVR]  = ovr;
    status[ST_FLAG] = flag_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      REG_DATA:  reg_rdata_o = ibuf;
      REG_STAT:  reg_rdata_o[ST_W-1:0] = status;
      REG_CTRL:  reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_LATCH: reg_rdata_o = host_data_i;
      default:   reg_rdata_o = '0;
    endcase
  end

  // strobed: drive only while host read strobe is low
  assign host_data_oe_o = ctrl_q.strobed ? ~host_rd_ni : 1'b1;
  assign host_data_o    = ctrl_q.strobed ? obuf : latch;
  assign host_flag_o    = {obf, ibf};
  assign irq_in_o       = ctrl_q.gie & ctrl_q.ie_in & ibf;
  assign irq_out_o      = ctrl_q.gie & ctrl_q.ie_out & pend;
endmodule

// File: rtl/hmb_chk.sv
module hmb_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobed,
  input logic              gie,
  input logic              ie_in,
  input logic              host_rd_ni,
  input logic [DATA_W-1:0] host_data_i,
  input logic [DATA_W-1:0] host_data_o,
  input logic              host_data_oe_o,
  input logic [DATA_W-1:0] latch,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic              data_rd,
  input logic              data_wr,
  input logic              ovr_clr,
  input logic [DATA_W-1:0] ibuf,
  input logic              ibf,
  input logic              obf,
  input logic              pend,
  input logic              ovr,
  input logic              irq_in_o
);
  // R2
  host_wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt |=> ibf && ibuf == $past(host_data_i));
  // R3
  drain_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd && !wr_evt |=> !ibf);
  // R4
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr && !ovr_clr |=> ovr);
  // R4
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt && ibf && !data_rd |=> ovr);
  // R5
  out_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> obf && !pend);
  // R6
  host_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt && !data_wr |=> !obf && pend);
  // R6
  drive_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobed |-> host_data_oe_o == !host_rd_ni);
  // R7
  plain_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobed |-> host_data_oe_o && host_data_o == latch && !wr_evt && !rd_evt);
  // R8
  irq_in_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_in_o |-> gie && ie_in && ibf);
endmodule

bind host_mailbox hmb_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .strobed       (ctrl_q.strobed),
  .gie           (ctrl_q.gie),
  .ie_in         (ctrl_q.ie_in),
  .host_rd_ni    (host_rd_ni),
  .host_data_i   (host_data_i),
  .host_data_o   (host_data_o),
  .host_data_oe_o(host_data_oe_o),
  .latch         (latch),
  .wr_evt        (wr_evt),
  .rd_evt        (rd_evt),
  .data_rd       (data_rd),
  .data_wr       (data_wr),
  .ovr_clr       (ovr_clr),
  .ibuf          (ibuf),
  .ibf           (ibf),
  .obf           (obf),
  .pend          (pend),
  .ovr           (ovr),
  .irq_in_o      (irq_in_o)
);

// File: tb/host_mailbox_tb_top.sv
module host_mailbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_data = '0;
  logic [7:0] host_data_o;
  logic       host_oe;
  logic       wr_n = 1'b1, rd_n = 1'b1, hflag = 1'b0;
  logic [1:0] hflag_o;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_in, irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model
  logic [7:0] m_ibuf = '0, m_obuf = '0, m_latch = '0;
  logic       m_ibf = 0, m_ovr = 0, m_flag = 0, m_obf = 0, m_pend = 0;
  logic [3:0] m_ctrl = 4'h1;

  always #2 clk = ~clk;

  host_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_data_i(host_data), .host_data_o(host_data_o), .host_data_oe_o(host_oe),
    .host_wr_ni(wr_n), .host_rd_ni(rd_n), .host_flag_i(hflag), .host_flag_o(hflag_o),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_in_o(irq_in), .irq_out_o(irq_out)
  );

  function automatic logic [7:0] exp_status();
    return {3'b000, m_flag, m_ovr, m_pend, m_obf, m_ibf};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) begin m_obuf = d; m_obf = 1; m_pend = 0; end
    if (a == 2'd1 && d[3]) m_ovr = 0;
    if (a == 2'd2) m_ctrl = d[3:0];
    if (a == 2'd3) m_latch = d;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    if (a == 2'd0) m_ibf = 0;
  endtask

  task automatic host_write(input logic [7:0] d, input logic f);
    @(negedge clk);
    host_data = d; hflag = f; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    if (m_ctrl[0]) begin
      if (m_ibf) m_ovr = 1;
      m_ibuf = d; m_flag = f; m_ibf = 1;
    end
  endtask

  task automatic host_read(input string req);
    logic [7:0] d;
    logic       oe;
    @(negedge clk);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 d = host_data_o; oe = host_oe;
    if (m_ctrl[0]) begin
      chk({req, " R6 drive low"}, {oe, d}, {1'b1, m_obuf});
      rd_n = 1'b1;
      #1 chk({req, " R6 release"}, host_oe, 1'b0);
      m_obf = 0; m_pend = 1;
    end else begin
      rd_n = 1'b1;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] s;
    reg_read(2'd1, s);
    chk({req, " status"}, s, exp_status());
    chk({req, " R8 irq"}, {irq_in, irq_out},
        {m_ctrl[3] & m_ctrl[1] & m_ibf, m_ctrl[3] & m_ctrl[2] & m_pend});
    chk({req, " R9 flags"}, hflag_o, {m_obf, m_ibf});
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", host_oe, 1'b0);
    rst_n = 1'b1;
    reg_read(2'd1, d); chk("R1 status", d, 8'h00);
    reg_read(2'd2, d); chk("R1 ctrl", d, 8'h01);
    chk("R1 irq", {irq_in, irq_out}, 2'b00);

    // R10 control readback, enables on
    reg_write(2'd2, 8'hFF); m_ctrl = 4'hF;
    reg_read(2'd2, d); chk("R10 ctrl", d, 8'h0F);

    // R2 / R3 basic write then drain
    host_write(8'h3C, 1'b1);
    check_all("R2");
    reg_read(2'd0, d); chk("R3 data", d, 8'h3C);
    check_all("R3");

    // R4 overrun and clear
    host_write(8'h11, 1'b0);
    host_write(8'h22, 1'b1);
    check_all("R4 set");
    reg_read(2'd0, d); chk("R4 latest data", d, 8'h22);
    check_all("R4 kept after drain");
    reg_write(2'd1, 8'h08);
    check_all("R4 cleared");

    // R5 / R6 output path
    reg_write(2'd0, 8'hA7);
    check_all("R5");
    host_read("R6");
    check_all("R6 status");
    reg_write(2'd0, 8'h5E);
    check_all("R5 pend cleared");

    // R7 non-strobed mode
    reg_write(2'd2, 8'h0E);
    reg_write(2'd3, 8'hC3);
    #1 chk("R7 drive", {host_oe, host_data_o}, {1'b1, 8'hC3});
    host_write(8'h99, 1'b1);
    host_read("R7");
    check_all("R7 strobes ignored");
    host_data = 8'h6D;
    reg_read(2'd3, d); chk("R7 pin read", d, 8'h6D);
    reg_write(2'd2, 8'h0F);

    // constrained random in strobed mode
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) host_write(8'($urandom), 1'($urandom));
      else if (op < 5) host_read("R6 rnd");
      else if (op < 7) begin
        reg_read(2'd0, d); chk("R3 rnd data", d, m_ibuf);
      end else if (op < 9) reg_write(2'd0, 8'($urandom));
      else if ($urandom_range(0, 1) == 0) reg_write(2'd1, 8'h08);
      else reg_write(2'd2, {4'h0, 3'($urandom), 1'b1});
      check_all("R2 R4 R5 rnd");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule